// File: doc/BRIEF.md
# One-Time-Programmable Memory Function Controller

This block is the command layer that sits behind a single-wire bit engine and in front of a one-time-programmable store. The store has a 128-byte data array and an 8-byte status array. Once the bit engine has selected the device, it passes each received byte to this controller. The controller decodes a function code and collects a two-byte target address. It then streams bytes back for the bit engine to send, or runs a byte-by-byte programming loop. In that loop the controller echoes a CRC, waits for a programming strobe, and returns the stored byte so the host can confirm it.

The CRC used everywhere is the 8-bit polynomial x^8+x^5+x^4+1. The register starts at zero and each byte enters least significant bit first. What the CRC covers depends on the command:
- the command and address header;
- all data since the start address;
- one 32-byte page at a time;
- or, on a continued write, a value seeded with the new low address byte.

Page protect flags held in status byte 0 decide whether a data-array program strobe takes effect. A reset strobe from the bit engine abandons any command at any point.

Both arrays are modelled as registers that power up erased, with every bit set to one. Programming can only clear bits.

Top module: `otp_func_ctrl`

## Requirements
- R1: The first byte after a line reset selects the operation: F0h reads the data array as one stream, C3h reads it page by page, AAh reads the status array, 0Fh programs data bytes and 55h programs status bytes. Any other code makes the controller ignore all traffic, so tx_valid stays 0 until the next line reset.
- R2: The next two received bytes are the low and high address bytes. Only the low 7 bits of the address are kept, and the CRC is taken over the masked bytes (low byte AND 7Fh, high byte treated as 00h). An address at or above 80h therefore behaves exactly like the address with bit 7 cleared.
- R3: For the three read codes, the first transmitted byte is the CRC of the command byte and the two masked address bytes.
- R4: With F0h, bytes are sent from the start address up to address 7Fh. Next comes one CRC of every data byte sent since the start. After that, every transmitted byte is FFh.
- R5: With C3h, a CRC of the bytes sent from the current page follows the last byte of each 32-byte page. The CRC then restarts from zero and reading continues at the next page. After the page-3 CRC, every transmitted byte is FFh.
- R6: With AAh, status bytes are sent through byte 7, followed by a CRC of the status bytes sent. Further reads return FFh up to address 7Fh, then resume from status byte 0 with a fresh CRC. FFh fill bytes do not enter the CRC.
- R7: For 0Fh and 55h, after the data byte the controller sends the CRC of the command, the masked address and the data byte. On each continued byte the address advances by one, and the CRC is loaded with the new 7-bit address (as a byte) before the data byte is shifted in.
- R8: A program strobe changes the addressed byte to its old value AND the data byte, so bits only go from 1 to 0. The next transmitted byte is the stored byte.
- R9: Bit p (p = 0..3) of status byte 0 protects data page p (addresses 32p to 32p+31) when it is 0. A program strobe to a protected page leaves the array unchanged, and the read-back shows the old byte.
- R10: Status bytes 5 and 6 always read FFh and status byte 7 always reads 00h; program strobes do not change them. After the read-back of the last byte of its field (data 7Fh, status 07h), a write command accepts nothing more and tx_valid stays 0.
- R11: A line_reset pulse ends any command in the next cycle, drops tx_valid and waits for a new command byte; no array byte changes.
- R12: After rst_n, tx_valid is 0 and every array byte reads FFh, except status byte 7, which reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; erases both arrays |
| line_reset | input | 1 | One-cycle pulse when the bit engine sees a bus reset |
| rx_valid | input | 1 | One-cycle pulse: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | One-cycle pulse: bit engine has taken tx_data |
| prog_strobe | input | 1 | One-cycle pulse marking the programming pulse |
| tx_valid | output | 1 | A byte is ready to be sent |
| tx_data | output | 8 | Byte to be sent |

## Verification
A table of read transactions covers each read code at several kinds of start address:
- the array start;
- just below the end of a page and of the array, which separates the per-page CRC from the whole-stream CRC and shows the FFh fill;
- an address with bit 7 set, which shows the mask acting before the header CRC;
- status addresses close to the wrap point, which show the fill and the restart at byte 0.

Directed write sequences check:
- single-byte and continued writes, where the seeded CRC of a continued byte differs from a plain running CRC;
- a second program of an already-cleared byte, which shows the AND;
- a protected page and the fixed status bytes, each of which must read back unchanged;
- the end-of-field stop, an unknown code, and an abort in the middle of a read.

// File: rtl/otp_pkg.sv
// Shared constants, state types and the byte-wide CRC step for the
// one-time-programmable memory function controller.
package otp_pkg;

    localparam logic [7:0] OP_RD_STREAM = 8'hF0;
    localparam logic [7:0] OP_RD_PAGED  = 8'hC3;
    localparam logic [7:0] OP_WR_DATA   = 8'h0F;
    localparam logic [7:0] OP_RD_STAT   = 8'hAA;
    localparam logic [7:0] OP_WR_STAT   = 8'h55;

    typedef enum logic [3:0] {
        ST_CMD, ST_TA1, ST_TA2, ST_HDR_CRC, ST_RD_BYTE, ST_RD_CRC, ST_RD_FILL,
        ST_WR_BYTE, ST_WR_CRC, ST_WR_PULSE, ST_WR_VERIFY, ST_HALT
    } ctl_state_t;

    typedef enum logic [2:0] {
        MODE_STREAM, MODE_PAGED, MODE_STAT, MODE_WDATA, MODE_WSTAT
    } op_mode_t;

    // One byte through the reflected x^8+x^5+x^4+1 CRC, LSB first.
    function automatic logic [7:0] crc8_step(input logic [7:0] cur, input logic [7:0] din);
        logic [7:0] c;
        logic       fb;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ din[i];
            c  = {1'b0, c[7:1]};
            if (fb) c = c ^ 8'h8C;
        end
        return c;
    endfunction

endpackage

// File: rtl/otp_crc_unit.sv
// CRC accumulator. Assumes at most one of clear/seed is requested per
// cycle; clear wins. An update in the same cycle as a seed is not used.
module otp_crc_unit
    import otp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       seed_en,
    input  logic [7:0] seed_val,
    input  logic       upd_en,
    input  logic [7:0] upd_val,
    output logic [7:0] crc
);

    // Hold, clear, load or advance the running CRC.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= 8'h00;
        else if (clr)     crc <= 8'h00;
        else if (seed_en) crc <= seed_val;
        else if (upd_en)  crc <= crc8_step(crc, upd_val);
    end

endmodule

// File: rtl/otp_data_array.sv
// Data array: BYTES bytes erased to FFh on reset, programmed by AND.
// A program request is honoured only if the page's protect bit is 1.
module otp_data_array #(
    parameter int BYTES      = 128,
    parameter int PAGE_BYTES = 32,
    localparam int AW        = $clog2(BYTES),
    localparam int PAGES     = BYTES / PAGE_BYTES,
    localparam int PGW       = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    rd_addr,
    input  logic             pgm_en,
    input  logic [AW-1:0]    pgm_addr,
    input  logic [7:0]       pgm_val,
    input  logic [PAGES-1:0] lock_n,
    output logic [7:0]       rd_byte,
    output logic [BYTES*8-1:0] mem_flat
);

    logic page_open;

    // Protect bit of the page being programmed (1 = writable).
    always_comb page_open = lock_n[pgm_addr[AW-1:PGW]];

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Erase on reset, clear bits on an allowed program request.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_flat[i*8 +: 8] <= 8'hFF;
            else if (pgm_en && page_open && pgm_addr == AW'(i))
                mem_flat[i*8 +: 8] <= mem_flat[i*8 +: 8] & pgm_val;
        end
    end

    // Read mux for the current address.
    always_comb rd_byte = mem_flat[rd_addr*8 +: 8];

endmodule

// File: rtl/otp_status_array.sv
// Status array: STORED programmable bytes, then fixed bytes up to
// FIELD_BYTES (last one reads 00h, others FFh). Addresses past the
// field read FFh. Byte 0's low bits are the page protect flags.
module otp_status_array #(
    parameter int AW          = 7,
    parameter int FIELD_BYTES = 8,
    parameter int STORED      = 5,
    parameter int PAGES       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    input  logic              pgm_en,
    input  logic [AW-1:0]     pgm_addr,
    input  logic [7:0]        pgm_val,
    output logic [7:0]        rd_byte,
    output logic [PAGES-1:0]  lock_n,
    output logic [STORED*8-1:0] stat_flat
);

    for (genvar i = 0; i < STORED; i++) begin : g_sbyte
        // Erase on reset, clear bits on a program request to this byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_flat[i*8 +: 8] <= 8'hFF;
            else if (pgm_en && pgm_addr == AW'(i))
                stat_flat[i*8 +: 8] <= stat_flat[i*8 +: 8] & pgm_val;
        end
    end

    // Stored bytes, fixed bytes, then FFh fill past the field.
    always_comb begin
        if (rd_addr < AW'(STORED))
            rd_byte = stat_flat[rd_addr*8 +: 8];
        else if (rd_addr == AW'(FIELD_BYTES - 1))
            rd_byte = 8'h00;
        else
            rd_byte = 8'hFF;
    end

    // Page protect flags from byte 0.
    always_comb lock_n = stat_flat[PAGES-1:0];

endmodule

// File: rtl/otp_func_ctrl.sv
// Function-command controller for a 128-byte OTP data array and an
// 8-byte status array. Assumes the bit engine delivers one-cycle
// rx_valid / tx_pop / prog_strobe pulses, and presents tx_data only
// while tx_valid is high. line_reset has priority over everything.
module otp_func_ctrl
    import otp_pkg::*;
#(
    parameter int DATA_BYTES  = 128,
    parameter int PAGE_BYTES  = 32,
    parameter int STAT_BYTES  = 8,
    parameter int STAT_STORED = 5,
    localparam int AW         = $clog2(DATA_BYTES),
    localparam int PAGES      = DATA_BYTES / PAGE_BYTES,
    localparam int PGW        = $clog2(PAGE_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       tx_pop,
    input  logic       prog_strobe,
    output logic       tx_valid,
    output logic [7:0] tx_data
);

    ctl_state_t state, state_nx;
    op_mode_t   mode, mode_nx;
    logic [AW-1:0] addr, addr_nx;
    logic [7:0]    wbyte, wbyte_nx;

    logic       crc_clr, crc_seed_en, crc_upd;
    logic [7:0] crc_seed, crc_in, crc;
    logic       pgm_data, pgm_stat, prog_hit_data;
    logic [7:0] data_rd, stat_rd, cur_byte;
    logic [PAGES-1:0] lock_n;
    logic [DATA_BYTES*8-1:0]  data_flat;
    logic [STAT_STORED*8-1:0] stat_flat;
    logic stat_side, field_last;

    otp_crc_unit u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .seed_en(crc_seed_en),
        .seed_val(crc_seed), .upd_en(crc_upd), .upd_val(crc_in), .crc(crc)
    );

    otp_data_array #(.BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_data (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .pgm_en(pgm_data),
        .pgm_addr(addr), .pgm_val(wbyte), .lock_n(lock_n),
        .rd_byte(data_rd), .mem_flat(data_flat)
    );

    otp_status_array #(.AW(AW), .FIELD_BYTES(STAT_BYTES), .STORED(STAT_STORED),
                       .PAGES(PAGES)) u_stat (
        .clk(clk), .rst_n(rst_n), .rd_addr(addr), .pgm_en(pgm_stat),
        .pgm_addr(addr), .pgm_val(wbyte), .rd_byte(stat_rd),
        .lock_n(lock_n), .stat_flat(stat_flat)
    );

    // Pick the array the current command works on.
    always_comb begin
        stat_side = (mode == MODE_STAT) || (mode == MODE_WSTAT);
        cur_byte  = stat_side ? stat_rd : data_rd;
    end

    // Last address of the current field for the active write command.
    always_comb field_last = (mode == MODE_WSTAT) ? (addr >= AW'(STAT_BYTES - 1))
                                                  : (addr == AW'(DATA_BYTES - 1));

    // Output byte and its valid flag, by state.
    always_comb begin
        tx_valid = 1'b1;
        tx_data  = 8'hFF;
        unique case (state)
            ST_HDR_CRC, ST_RD_CRC, ST_WR_CRC: tx_data = crc;
            ST_RD_BYTE, ST_WR_VERIFY:         tx_data = cur_byte;
            ST_RD_FILL:                       tx_data = 8'hFF;
            default:                          tx_valid = 1'b0;
        endcase
    end

    // Next state, address, CRC control and program requests.
    always_comb begin
        state_nx = state;   mode_nx = mode;  addr_nx = addr;  wbyte_nx = wbyte;
        crc_clr = 1'b0;     crc_seed_en = 1'b0; crc_seed = 8'h00;
        crc_upd = 1'b0;     crc_in = 8'h00;
        pgm_data = 1'b0;    pgm_stat = 1'b0;
        unique case (state)
            ST_CMD: if (rx_valid) begin
                crc_upd  = 1'b1;
                crc_in   = rx_data;
                state_nx = ST_TA1;
                case (rx_data)
                    OP_RD_STREAM: mode_nx = MODE_STREAM;
                    OP_RD_PAGED:  mode_nx = MODE_PAGED;
                    OP_RD_STAT:   mode_nx = MODE_STAT;
                    OP_WR_DATA:   mode_nx = MODE_WDATA;
                    OP_WR_STAT:   mode_nx = MODE_WSTAT;
                    default:      state_nx = ST_HALT;
                endcase
            end
            ST_TA1: if (rx_valid) begin
                addr_nx  = rx_data[AW-1:0];
                crc_upd  = 1'b1;
                crc_in   = 8'({rx_data[AW-1:0]});
                state_nx = ST_TA2;
            end
            ST_TA2: if (rx_valid) begin
                crc_upd  = 1'b1;
                crc_in   = 8'h00;
                state_nx = (mode == MODE_WDATA || mode == MODE_WSTAT) ? ST_WR_BYTE
                                                                      : ST_HDR_CRC;
            end
            ST_HDR_CRC: if (tx_pop) begin
                crc_clr  = 1'b1;
                state_nx = ST_RD_BYTE;
            end
            ST_RD_BYTE: if (tx_pop) begin
                crc_upd = !stat_side || (addr < AW'(STAT_BYTES));
                crc_in  = cur_byte;
                addr_nx = addr + 1'b1;
                if ((mode == MODE_STREAM && addr == AW'(DATA_BYTES - 1)) ||
                    (mode == MODE_PAGED  && addr[PGW-1:0] == '1) ||
                    (mode == MODE_STAT   && addr == AW'(STAT_BYTES - 1)))
                    state_nx = ST_RD_CRC;
            end
            ST_RD_CRC: if (tx_pop) begin
                if (mode == MODE_STREAM || (mode == MODE_PAGED && addr == '0)) begin
                    state_nx = ST_RD_FILL;
                end else begin
                    crc_clr  = 1'b1;
                    state_nx = ST_RD_BYTE;
                end
            end
            ST_WR_BYTE: if (rx_valid) begin
                wbyte_nx = rx_data;
                crc_upd  = 1'b1;
                crc_in   = rx_data;
                state_nx = ST_WR_CRC;
            end
            ST_WR_CRC: if (tx_pop) state_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (prog_strobe) begin
                pgm_data = (mode == MODE_WDATA);
                pgm_stat = (mode == MODE_WSTAT);
                state_nx = ST_WR_VERIFY;
            end
            ST_WR_VERIFY: if (tx_pop) begin
                if (field_last) begin
                    state_nx = ST_HALT;
                end else begin
                    addr_nx     = addr + 1'b1;
                    crc_seed_en = 1'b1;
                    crc_seed    = 8'(addr + 1'b1);
                    state_nx    = ST_WR_BYTE;
                end
            end
            default: ;
        endcase
        if (line_reset) begin
            state_nx = ST_CMD;
            crc_clr  = 1'b1;
            pgm_data = 1'b0;
            pgm_stat = 1'b0;
        end
    end

    // Data-array program request, visible to the checker.
    always_comb prog_hit_data = pgm_data;

    // State, mode, address and write-byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CMD;
            mode  <= MODE_STREAM;
            addr  <= '0;
            wbyte <= 8'hFF;
        end else begin
            state <= state_nx;
            mode  <= mode_nx;
            addr  <= addr_nx;
            wbyte <= wbyte_nx;
        end
    end

endmodule

// File: rtl/otp_func_ctrl_chk.sv
// Assertion checker for otp_func_ctrl, attached by bind below.
module otp_func_ctrl_chk #(
    parameter int DATA_BYTES  = 128,
    parameter int STAT_STORED = 5,
    parameter int PAGE_BYTES  = 32,
    localparam int AW         = $clog2(DATA_BYTES),
    localparam int PAGES      = DATA_BYTES / PAGE_BYTES,
    localparam int PGW        = $clog2(PAGE_BYTES)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     line_reset,
    input logic                     tx_valid,
    input logic                     prog_hit_data,
    input logic [AW-1:0]            addr,
    input logic [PAGES-1:0]         lock_n,
    input logic [DATA_BYTES*8-1:0]  data_flat,
    input logic [STAT_STORED*8-1:0] stat_flat
);

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        line_reset |=> !tx_valid);                                           // R11

    AST_DATA_ONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ~|(data_flat & ~$past(data_flat)));                                  // R8

    AST_STAT_ONE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        ~|(stat_flat & ~$past(stat_flat)));                                  // R8

    AST_LOCKED_PAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_hit_data && !lock_n[addr[AW-1:PGW]]) |=> $stable(data_flat));  // R9

endmodule

bind otp_func_ctrl otp_func_ctrl_chk #(
    .DATA_BYTES(DATA_BYTES), .STAT_STORED(STAT_STORED), .PAGE_BYTES(PAGE_BYTES)
) chk_i (
    .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .tx_valid(tx_valid),
    .prog_hit_data(prog_hit_data), .addr(addr), .lock_n(lock_n),
    .data_flat(data_flat), .stat_flat(stat_flat)
);

// File: tb/otp_func_ctrl_tb_top.sv
`timescale 1ns/1ps
module otp_func_ctrl_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_reset = 1'b0, rx_valid = 1'b0, tx_pop = 1'b0, prog_strobe = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic tx_valid;
    logic [7:0] tx_data;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [7:0] m_data [128];
    logic [7:0] m_stat [8];

    // {cmd, ta1, ta2, number of bytes popped after the header CRC}
    localparam logic [31:0] VEC [8] = '{
        32'hF0_00_00_06,   // R4 start of array, sees programmed bytes 3 and 4
        32'hF0_7E_00_05,   // R4 end of array: 7E, 7F, CRC, fill
        32'hF0_85_12_03,   // R2 masked to 05
        32'hC3_1E_00_05,   // R5 page 0 end, CRC, page 1 start
        32'hC3_7F_00_04,   // R5 last byte, final CRC, fill
        32'hAA_00_00_0A,   // R6 whole status field and CRC
        32'hAA_06_00_05,   // R6 field end, CRC, fill
        32'hAA_7E_00_05    // R6 fill, then resume at byte 0
    };

    otp_func_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .rx_valid(rx_valid),
        .rx_data(rx_data), .tx_pop(tx_pop), .prog_strobe(prog_strobe),
        .tx_valid(tx_valid), .tx_data(tx_data)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 8'h8C;
            else             r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [7:0] act,
                         input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic pop_check(input logic [7:0] exp, input string tag);
        @(negedge clk);
        check(tx_valid === 1'b1, {tag, " valid"}, {7'd0, tx_valid}, 8'h01);
        check(tx_data === exp, tag, tx_data, exp);
        tx_pop = 1'b1;
        @(negedge clk); tx_pop = 1'b0;
    endtask

    task automatic pulse_line_reset();
        @(negedge clk); line_reset = 1'b1;
        @(negedge clk); line_reset = 1'b0;
    endtask

    task automatic expect_quiet(input string tag);
        @(negedge clk);
        check(tx_valid === 1'b0, tag, {7'd0, tx_valid}, 8'h00);
    endtask

    function automatic logic [7:0] stat_at(input logic [6:0] a);
        return (a < 8) ? m_stat[a[2:0]] : 8'hFF;
    endfunction

    // Read transaction against the bench model.
    task automatic do_read(input logic [7:0] cmd, input logic [7:0] ta1,
                           input logic [7:0] ta2, input int n);
        logic [6:0] a = ta1[6:0];
        logic [7:0] c = crc_b(crc_b(crc_b(8'h00, cmd), {1'b0, ta1[6:0]}), 8'h00);
        int phase = 0;   // 0 data, 1 trailing CRC, 2 fill
        string tg = (cmd == 8'hF0) ? "R4" : (cmd == 8'hC3) ? "R5" : "R6";
        send(cmd); send(ta1); send(ta2);
        pop_check(c, ta1[7] ? "R2 header CRC" : "R3 header CRC");
        c = 8'h00;
        for (int k = 0; k < n; k++) begin
            if (phase == 0) begin
                logic [7:0] b = (cmd == 8'hAA) ? stat_at(a) : m_data[a];
                pop_check(b, {tg, " data"});
                if (cmd != 8'hAA || a < 8) c = crc_b(c, b);
                if ((cmd == 8'hF0 && a == 7'h7F) || (cmd == 8'hC3 && a[4:0] == 5'h1F) ||
                    (cmd == 8'hAA && a == 7'h07)) phase = 1;
                a = a + 7'd1;
            end else if (phase == 1) begin
                pop_check(c, {tg, " trailing CRC"});
                if (cmd == 8'hF0 || (cmd == 8'hC3 && a == 7'h00)) phase = 2;
                else begin phase = 0; c = 8'h00; end
            end else begin
                pop_check(8'hFF, {tg, " fill"});
            end
        end
        pulse_line_reset();
    endtask

    // Write transaction of n bytes (1..3) against the bench model.
    task automatic do_write(input logic [7:0] cmd, input logic [7:0] ta1, input int n,
                            input logic [7:0] d0, input logic [7:0] d1,
                            input logic [7:0] d2, input string tag);
        logic [6:0] a = ta1[6:0];
        logic [7:0] c = crc_b(crc_b(crc_b(8'h00, cmd), {1'b0, ta1[6:0]}), 8'h00);
        logic [7:0] d, old;
        bit wr_ok;
        send(cmd); send(ta1); send(8'h00);
        for (int k = 0; k < n; k++) begin
            d = (k == 0) ? d0 : (k == 1) ? d1 : d2;
            if (k > 0) begin
                a = a + 7'd1;
                c = {1'b0, a};
            end
            send(d);
            c = crc_b(c, d);
            pop_check(c, "R7 write CRC");
            @(negedge clk); prog_strobe = 1'b1;
            @(negedge clk); prog_strobe = 1'b0;
            if (cmd == 8'h55) begin
                old = stat_at(a);
                wr_ok = (a < 5);
                if (wr_ok) m_stat[a[2:0]] = old & d;
                pop_check(wr_ok ? (old & d) : old, tag);
            end else begin
                old = m_data[a];
                wr_ok = m_stat[0][a[6:5]];
                if (wr_ok) m_data[a] = old & d;
                pop_check(wr_ok ? (old & d) : old, tag);
            end
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_data[i] = 8'hFF;
        for (int i = 0; i < 7; i++) m_stat[i] = 8'hFF;
        m_stat[7] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_quiet("R12 reset tx_valid");
        do_read(8'hF0, 8'h7C, 8'h00, 4);   // R12 erased bytes read FFh

        // Directed writes (R7, R8, R9, R10).
        do_write(8'h0F, 8'h03, 2, 8'hA5, 8'h3C, 8'h00, "R8 program read-back");
        pulse_line_reset();
        do_write(8'h0F, 8'h03, 1, 8'h0F, 8'h00, 8'h00, "R8 AND of second program");
        pulse_line_reset();
        do_write(8'h55, 8'h00, 1, 8'hFD, 8'h00, 8'h00, "R9 set page 1 protect");
        pulse_line_reset();
        do_write(8'h0F, 8'h25, 1, 8'h00, 8'h00, 8'h00, "R9 protected page unchanged");
        pulse_line_reset();
        do_write(8'h55, 8'h01, 2, 8'h12, 8'h34, 8'h00, "R7 status continued write");
        pulse_line_reset();
        do_write(8'h55, 8'h05, 3, 8'h00, 8'h00, 8'h00, "R10 fixed status bytes");
        send(8'h00);
        expect_quiet("R10 status field end stops write");
        pulse_line_reset();
        do_write(8'h0F, 8'h7F, 1, 8'h7E, 8'h00, 8'h00, "R8 last data byte");
        send(8'h00);
        expect_quiet("R10 data field end stops write");
        pulse_line_reset();

        // Vector table of read transactions (R2..R6).
        for (int v = 0; v < 8; v++)
            do_read(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], int'(VEC[v][7:0]));

        // R1: unknown command ignores all further traffic.
        send(8'h99); send(8'h00); send(8'h00);
        expect_quiet("R1 unknown command");
        send(8'hF0);
        expect_quiet("R1 still ignored before line reset");
        pulse_line_reset();

        // R11: abort in the middle of a read, then arrays intact.
        send(8'hF0); send(8'h03); send(8'h00);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        pulse_line_reset();
        expect_quiet("R11 abort drops tx_valid");
        do_read(8'hF0, 8'h03, 8'h00, 2);

        // R11: line reset in the program-pulse window leaves the byte alone.
        send(8'h0F); send(8'h10); send(8'h00); send(8'h00);
        @(negedge clk); tx_pop = 1'b1; @(negedge clk); tx_pop = 1'b0;
        @(negedge clk); line_reset = 1'b1; prog_strobe = 1'b1;
        @(negedge clk); line_reset = 1'b0; prog_strobe = 1'b0;
        do_read(8'hF0, 8'h10, 8'h00, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule